// File: doc/BRIEF.md
# I2C Target Controller with Direction Reversal

This block is an I2C target that answers one fixed 7-bit address. It samples the open-drain SCL and SDA lines, passes them through an internal synchroniser and edge detectors, and finds START, STOP and the bits of each byte. When the address matches, it acknowledges and then either receives bytes into a receive holding register or sends bytes from a transmit holding register. The R/W bit of the address byte selects which of the two it does.

Within one transaction the controller may issue a repeated START and address the target again with the opposite R/W bit. The block then matches the address again and turns the data direction around. Transfer-complete stays low until the final STOP. When the target has nothing to send, or has nowhere to put a received byte, it holds SCL low until local logic services the holding register. A single-cycle write strobe loads the transmit holding register, and a single-cycle read strobe empties the receive holding register.

Top module: `i2c_tgt_rev`

## Requirements
- R1: When the 7-bit address (MSB first, R/W as the eighth bit, 1 = read) equals TGT_ADDR, the target pulls SDA low through the ninth clock. It also sets `sts_addressed`, loads `sts_read` from the R/W bit and clears `sts_eoa` and `sts_done`.
- R2: On an address mismatch the target drives no ACK and changes no flag. It ignores the bus until the next START.
- R3: In a write phase, each received byte (MSB first) is placed in the receive holding register. The target sets `sts_rxrdy` and acknowledges the byte. A `rd_en` strobe clears `sts_rxrdy`.
- R4: If a byte completes while the receive holding register is still full, the target holds SCL low before the ACK. The held byte stays unchanged until `rd_en`. The new byte is then stored and acknowledged.
- R5: In a read phase, the transmit holding byte is shifted out MSB first, and SDA changes only while SCL is low. A `wr_en` strobe clears `sts_txrdy`. `sts_txrdy` returns to 1 when the byte moves into the shifter.
- R6: A byte is due after a read address and after each controller ACK. If the transmit holding register is empty at that point, the target holds SCL low until `wr_en` supplies data.
- R7: A controller NACK ends the transmit run. SDA is released, and no further byte leaves the transmit holding register.
- R8: Any START, first or repeated, clears `sts_addressed` at once and sets `sts_eoa` if the target had been addressed. STOP does the same.
- R9: After a repeated START the target matches the address again and takes `sts_read` from the new R/W bit. `sts_done` stays 0 across the repeated START and rises only at STOP.
- R10: After reset: `sda_oe`=0, `scl_hold`=0, `sts_txrdy`=1, `sts_rxrdy`=0, `sts_addressed`=0, `sts_read`=0, `sts_eoa`=0, `sts_done`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_hold | output | 1 | 1 pulls SCL low (clock stretch) |
| wr_en | input | 1 | Strobe: load transmit holding register |
| wr_data | input | 8 | Byte for the transmit holding register |
| rd_en | input | 1 | Strobe: empty receive holding register |
| rd_data | output | 8 | Receive holding register contents |
| sts_addressed | output | 1 | Target currently addressed |
| sts_read | output | 1 | Current phase is a read (target transmits) |
| sts_txrdy | output | 1 | Transmit holding register empty |
| sts_rxrdy | output | 1 | Receive holding register full |
| sts_eoa | output | 1 | An addressed access has ended |
| sts_done | output | 1 | Transaction finished by STOP |

## Verification
The assertions assume the following about the inputs:
- `scl_i` and `sda_i` are the wired line levels, so the target's own SCL hold shows up on `scl_i`.
- The controller keeps SCL low for many more clocks than the synchroniser and edge-detector delay.
- The controller moves SDA only while SCL is low, except for START and STOP.
- `wr_en` and `rd_en` are single-cycle strobes.

The bench models both lines as wired-AND of controller and target. It uses quarter-bit phases of 20 clocks and re-aligns to the falling clock edge after every stretched SCL release. As a result, no bus event lands on an active edge.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = $clog2(BYTE_W + 1);

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_WAIT_A,
      ST_ACK_A,
      ST_TX,
      ST_TX_ACK,
      ST_WAIT_T,
      ST_RX,
      ST_WAIT_R,
      ST_ACK_R
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_pinsync.sv
module i2c_tgt_pinsync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_tgt_pinsync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q, scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_holdregs.sv
module i2c_tgt_holdregs
   import i2c_tgt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              tx_take,
   output logic [BYTE_W-1:0] tx_byte,
   output logic              tx_full,
   input  logic              rd_en,
   input  logic              rx_put,
   input  logic [BYTE_W-1:0] rx_byte,
   output logic [BYTE_W-1:0] rx_data,
   output logic              rx_full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_byte <= '0;
         tx_full <= 1'b0;
      end else begin
         if (tx_take) tx_full <= 1'b0;
         if (wr_en) begin
            tx_byte <= wr_data;
            tx_full <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
      end else begin
         if (rd_en) rx_full <= 1'b0;
         if (rx_put) begin
            rx_data <= rx_byte;
            rx_full <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] tx_byte,
   input  logic              tx_full,
   input  logic              rx_full,
   output logic              tx_take,
   output logic              rx_put,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              sda_oe,
   output logic              scl_hold,
   output logic              addressed,
   output logic              rd_dir,
   output logic              eoa,
   output logic              done
);
   tgt_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] sh;
   logic              mnack;
   logic              bus_evt, byte_end, addr_hit;

   assign bus_evt  = start_det | stop_det;
   assign byte_end = scl_fall && (cnt == CNT_W'(BYTE_W));
   assign addr_hit = (st == ST_ADDR) && byte_end && (sh[7:1] == TGT_ADDR);

   assign tx_take = !bus_evt && tx_full &&
                    ((addr_hit && sh[0]) || (st == ST_WAIT_A) || (st == ST_WAIT_T) ||
                     ((st == ST_TX_ACK) && scl_fall && !mnack));
   assign rx_put  = !bus_evt && !rx_full &&
                    (((st == ST_RX) && byte_end) || (st == ST_WAIT_R));
   assign rx_byte = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cnt       <= '0;
         sh        <= '0;
         mnack     <= 1'b0;
         sda_oe    <= 1'b0;
         scl_hold  <= 1'b0;
         addressed <= 1'b0;
         rd_dir    <= 1'b0;
         eoa       <= 1'b0;
         done      <= 1'b1;
      end else begin
         scl_hold <= (st == ST_WAIT_A) || (st == ST_WAIT_T) || (st == ST_WAIT_R);
         if (start_det) begin
            st        <= ST_ADDR;
            cnt       <= '0;
            sda_oe    <= 1'b0;
            addressed <= 1'b0;
            if (addressed) eoa <= 1'b1;
         end else if (stop_det) begin
            st        <= ST_IDLE;
            sda_oe    <= 1'b0;
            addressed <= 1'b0;
            done      <= 1'b1;
            if (addressed) eoa <= 1'b1;
         end else begin
            case (st)
               ST_ADDR: begin
                  if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (byte_end) begin
                     if (addr_hit) begin
                        addressed <= 1'b1;
                        eoa       <= 1'b0;
                        done      <= 1'b0;
                        rd_dir    <= sh[0];
                        if (!sh[0]) begin
                           sda_oe <= 1'b1;
                           st     <= ST_ACK_A;
                        end else if (tx_full) begin
                           sh     <= tx_byte;
                           sda_oe <= 1'b1;
                           st     <= ST_ACK_A;
                        end else begin
                           st <= ST_WAIT_A;
                        end
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_WAIT_A: if (tx_full) begin
                  sh     <= tx_byte;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK_A;
               end
               ST_ACK_A: if (scl_fall) begin
                  cnt <= '0;
                  if (rd_dir) begin
                     sda_oe <= ~sh[BYTE_W-1];
                     st     <= ST_TX;
                  end else begin
                     sda_oe <= 1'b0;
                     st     <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (byte_end) begin
                     sda_oe <= 1'b0;
                     st     <= ST_TX_ACK;
                  end else if (scl_fall) begin
                     sh     <= {sh[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~sh[BYTE_W-2];
                  end
               end
               ST_TX_ACK: begin
                  if (scl_rise) begin
                     mnack <= sda_s;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (mnack) begin
                        st <= ST_IDLE;
                     end else if (tx_full) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[BYTE_W-1];
                        st     <= ST_TX;
                     end else begin
                        st <= ST_WAIT_T;
                     end
                  end
               end
               ST_WAIT_T: if (tx_full) begin
                  sh     <= tx_byte;
                  sda_oe <= ~tx_byte[BYTE_W-1];
                  st     <= ST_TX;
               end
               ST_RX: begin
                  if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
                     sh  <= {sh[BYTE_W-2:0], sda_s};
                     cnt <= cnt + 1'b1;
                  end else if (byte_end) begin
                     if (!rx_full) begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK_R;
                     end else begin
                        st <= ST_WAIT_R;
                     end
                  end
               end
               ST_WAIT_R: if (!rx_full) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ACK_R;
               end
               ST_ACK_R: if (scl_fall) begin
                  sda_oe <= 1'b0;
                  cnt    <= '0;
                  st     <= ST_RX;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_tgt_rev.sv
module i2c_tgt_rev
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR    = 7'h2A,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       scl_hold,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       sts_addressed,
   output logic       sts_read,
   output logic       sts_txrdy,
   output logic       sts_rxrdy,
   output logic       sts_eoa,
   output logic       sts_done
);
   generate
      if (TGT_ADDR == 7'h00) begin : g_bad_addr
         $error("i2c_tgt_rev: address 0 is reserved");
      end
      if (BYTE_W != 8) begin : g_bad_width
         $error("i2c_tgt_rev: byte width must be 8");
      end
   endgenerate

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              tx_take, rx_put, tx_full, rx_full;
   logic [BYTE_W-1:0] tx_byte, rx_byte;

   i2c_tgt_pinsync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2c_tgt_engine #(.TGT_ADDR(TGT_ADDR)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .tx_byte(tx_byte), .tx_full(tx_full), .rx_full(rx_full),
      .tx_take(tx_take), .rx_put(rx_put), .rx_byte(rx_byte),
      .sda_oe(sda_oe), .scl_hold(scl_hold), .addressed(sts_addressed),
      .rd_dir(sts_read), .eoa(sts_eoa), .done(sts_done)
   );

   i2c_tgt_holdregs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tx_take(tx_take), .tx_byte(tx_byte), .tx_full(tx_full),
      .rd_en(rd_en), .rx_put(rx_put), .rx_byte(rx_byte),
      .rx_data(rd_data), .rx_full(rx_full)
   );

   assign sts_txrdy = ~tx_full;
   assign sts_rxrdy = rx_full;
endmodule

// File: rtl/i2c_tgt_rev_chk.sv
module i2c_tgt_rev_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       scl_hold,
   input logic       wr_en,
   input logic       rd_en,
   input logic [7:0] rd_data,
   input logic       sts_addressed,
   input logic       sts_txrdy,
   input logic       sts_rxrdy,
   input logic       sts_eoa,
   input logic       sts_done
);
   assert_ack_or_stretch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_addressed) |=> (sda_oe || scl_hold));

   assert_done_clears_on_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_done) |-> sts_addressed);

   assert_rx_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sts_rxrdy) |=> !sts_rxrdy);

   assert_rx_no_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_rxrdy && !rd_en) |=> $stable(rd_data));

   assert_sda_moves_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   assert_tx_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !sts_txrdy);

   assert_hold_keeps_line_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> !scl_i);

   assert_access_end_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_addressed) |-> sts_eoa);

   assert_done_only_at_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_done) |-> !sts_addressed);
endmodule

bind i2c_tgt_rev i2c_tgt_rev_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .scl_hold(scl_hold), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
   .sts_addressed(sts_addressed), .sts_txrdy(sts_txrdy),
   .sts_rxrdy(sts_rxrdy), .sts_eoa(sts_eoa), .sts_done(sts_done)
);

// File: tb/i2c_tgt_rev_tb.sv
`timescale 1ns/1ps
module i2c_tgt_rev_tb;
   localparam logic [6:0] ADDR = 7'h2A;
   localparam int QNS = 160;
   // fields: [15:9] address, [8] expect match, [7:0] data byte
   localparam logic [15:0] VEC [4] = '{
      {7'h2A, 1'b1, 8'hA5},
      {7'h2A, 1'b1, 8'h3C},
      {7'h15, 1'b0, 8'hFF},
      {7'h2B, 1'b0, 8'h00}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic sda_oe, scl_hold, scl_line, sda_line;
   logic [7:0] rd_data;
   logic sts_addressed, sts_read, sts_txrdy, sts_rxrdy, sts_eoa, sts_done;
   int checks = 0, errors = 0;
   logic finished = 1'b0;

   logic ack, ack2, junk;
   logic [7:0] b1, b2, v;

   always #4 clk = ~clk;
   assign scl_line = scl_m & ~scl_hold;
   assign sda_line = sda_m & ~sda_oe;

   i2c_tgt_rev #(.TGT_ADDR(ADDR)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .sda_oe(sda_oe), .scl_hold(scl_hold), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .sts_addressed(sts_addressed),
      .sts_read(sts_read), .sts_txrdy(sts_txrdy), .sts_rxrdy(sts_rxrdy),
      .sts_eoa(sts_eoa), .sts_done(sts_done)
   );

   task automatic chk1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic scl_up;
      scl_m = 1'b1;
      wait (scl_line === 1'b1);
      @(negedge clk);
   endtask

   task automatic bus_bit(input logic b, output logic s);
      sda_m = b;
      #QNS;
      scl_up();
      #QNS;
      s = sda_line;
      #QNS;
      scl_m = 1'b0;
      #QNS;
   endtask

   task automatic bus_start;
      sda_m = 1'b1;
      #QNS;
      scl_up();
      #QNS;
      sda_m = 1'b0;
      #QNS;
      scl_m = 1'b0;
      #QNS;
   endtask

   task automatic bus_stop;
      sda_m = 1'b0;
      #QNS;
      scl_up();
      #QNS;
      sda_m = 1'b1;
      #QNS;
   endtask

   task automatic send_byte(input logic [7:0] d, output logic a);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
      bus_bit(1'b1, a);
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         d[i] = s;
      end
      bus_bit(nack, s);
   endtask

   task automatic host_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic host_read(output logic [7:0] d);
      @(negedge clk);
      d = rd_data;
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      // R10 reset state
      chk1("R10 sda_oe", sda_oe, 1'b0);
      chk1("R10 scl_hold", scl_hold, 1'b0);
      chk1("R10 txrdy", sts_txrdy, 1'b1);
      chk1("R10 rxrdy", sts_rxrdy, 1'b0);
      chk1("R10 addressed", sts_addressed, 1'b0);
      chk1("R10 read", sts_read, 1'b0);
      chk1("R10 eoa", sts_eoa, 1'b0);
      chk1("R10 done", sts_done, 1'b1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // table of single-byte write transactions
      for (int k = 0; k < 4; k++) begin
         bus_start();
         send_byte({VEC[k][15:9], 1'b0}, ack);
         if (VEC[k][8]) begin
            chk1("R1 address ack", ack, 1'b0);
            chk1("R1 addressed", sts_addressed, 1'b1);
            chk1("R1 read flag", sts_read, 1'b0);
            chk1("R1 done cleared", sts_done, 1'b0);
            send_byte(VEC[k][7:0], ack);
            chk1("R3 data ack", ack, 1'b0);
            chk1("R3 rxrdy set", sts_rxrdy, 1'b1);
            host_read(v);
            chk8("R3 data", v, VEC[k][7:0]);
            chk1("R3 rxrdy cleared", sts_rxrdy, 1'b0);
            bus_stop();
            chk1("R8 addressed after stop", sts_addressed, 1'b0);
            chk1("R8 eoa after stop", sts_eoa, 1'b1);
            chk1("R9 done after stop", sts_done, 1'b1);
         end else begin
            chk1("R2 no address ack", ack, 1'b1);
            chk1("R2 addressed", sts_addressed, 1'b0);
            chk1("R2 done", sts_done, 1'b1);
            send_byte(VEC[k][7:0], ack);
            chk1("R2 no data ack", ack, 1'b1);
            chk1("R2 rxrdy", sts_rxrdy, 1'b0);
            bus_stop();
            chk1("R2 eoa untouched", sts_eoa, 1'b1);
         end
      end

      // R4 receive holding register full
      bus_start();
      send_byte({ADDR, 1'b0}, ack);
      send_byte(8'h11, ack);
      fork
         send_byte(8'h22, ack2);
         begin
            repeat (1500) @(negedge clk);
            chk1("R4 scl held", scl_hold, 1'b1);
            chk1("R4 line low", scl_line, 1'b0);
            chk8("R4 byte kept", rd_data, 8'h11);
            host_read(v);
            chk8("R4 first byte", v, 8'h11);
         end
      join
      chk1("R4 ack after release", ack2, 1'b0);
      host_read(v);
      chk8("R4 second byte", v, 8'h22);
      bus_stop();

      // read then repeated START into write (R5 R7 R8 R9)
      host_write(8'hC3);
      chk1("R5 txrdy cleared", sts_txrdy, 1'b0);
      bus_start();
      send_byte({ADDR, 1'b1}, ack);
      chk1("R1 read address ack", ack, 1'b0);
      chk1("R1 read flag set", sts_read, 1'b1);
      chk1("R5 txrdy after load", sts_txrdy, 1'b1);
      host_write(8'h5A);
      recv_byte(1'b0, b1);
      chk8("R5 first byte out", b1, 8'hC3);
      recv_byte(1'b1, b2);
      chk8("R5 second byte out", b2, 8'h5A);
      host_write(8'h99);
      bus_start();
      chk1("R8 Sr clears addressed", sts_addressed, 1'b0);
      chk1("R8 Sr sets eoa", sts_eoa, 1'b1);
      chk1("R9 done low at Sr", sts_done, 1'b0);
      send_byte({ADDR, 1'b0}, ack);
      chk1("R9 rematch ack", ack, 1'b0);
      chk1("R9 read flag cleared", sts_read, 1'b0);
      send_byte(8'h44, ack);
      host_read(v);
      chk8("R3 byte after reversal", v, 8'h44);
      bus_stop();
      chk1("R7 byte not taken after nack", sts_txrdy, 1'b0);
      chk1("R9 done at stop", sts_done, 1'b1);

      // write then repeated START into read (R9 R7)
      bus_start();
      send_byte({ADDR, 1'b0}, ack);
      send_byte(8'h77, ack);
      host_read(v);
      chk8("R3 byte before reversal", v, 8'h77);
      bus_start();
      send_byte({ADDR, 1'b1}, ack);
      chk1("R9 read flag set", sts_read, 1'b1);
      chk1("R9 done stays low", sts_done, 1'b0);
      recv_byte(1'b1, b1);
      chk8("R7 pending byte sent next phase", b1, 8'h99);
      bus_stop();
      chk1("R9 done final", sts_done, 1'b1);

      // R6 transmit holding register empty
      chk1("R6 precondition txrdy", sts_txrdy, 1'b1);
      fork
         begin
            bus_start();
            send_byte({ADDR, 1'b1}, ack);
            recv_byte(1'b0, b1);
            recv_byte(1'b1, b2);
         end
         begin
            repeat (1500) @(negedge clk);
            chk1("R6 hold before address ack", scl_hold, 1'b1);
            host_write(8'h6E);
            repeat (3) @(negedge clk);
            wait (scl_hold === 1'b1);
            repeat (50) @(negedge clk);
            chk1("R6 hold after controller ack", scl_line, 1'b0);
            host_write(8'h81);
         end
      join
      chk1("R6 address ack", ack, 1'b0);
      chk8("R6 first byte", b1, 8'h6E);
      chk8("R6 second byte", b2, 8'h81);
      bus_stop();
      chk1("R6 hold released", scl_hold, 1'b0);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule